// File: doc/BRIEF.md
# Atomic line lock for read-modify-write

This block keeps an atomic read-modify-write sequence on one cache line intact. It sits between a requester and a simple tag/data array. A locked read brings the line in with exclusive ownership and returns its data. If the line is absent, the read goes through a downstream fetch and fill first. The line then stays locked. The lock is a held miss-status entry plus cleared line permissions. Every later access to that line, other than the paired locked write, becomes a miss and is appended to that entry's target queue. This includes plain requester reads and writes and incoming snoops.

The paired locked write always hits. It restores access, commits its data to the array and answers without data. The already-answered locked read is then dropped from the entry without a second answer. The deferred targets are replayed one per clock, in the order they arrived. While the line is locked, requests to any other line are held off. When the target queue is full, further requests and snoops for the locked line are held off as well.

Top module: `rmw_line_lock`

## Requirements
- R1: After reset `rsp_valid`, `lock_busy`, `lock_err` and `fetch_valid` are 0, and `req_ready` is 1.
- R2: Commands are encoded 0 read, 1 write, 2 locked read, 3 locked write. Response kinds are 1 read, 2 write, 3 locked read, 4 locked write, 5 snoop completion. With no lock, a read that hits answers one cycle after acceptance with kind 1 and the array data. A write updates the array at the acceptance edge and answers one cycle later with kind 2 and data 0.
- R3: A locked read that hits answers one cycle after acceptance with kind 3 and the line data. It issues no fetch (`fetch_valid` stays 0), and `lock_busy` is 1 from that cycle on.
- R4: A locked read that misses raises `fetch_valid` with the line address in `fetch_addr`. The cycle after `fill_valid`, it answers kind 3 with the fill data, writes that data into the array and keeps the line locked.
- R5: While locked, plain reads and writes to the locked line are accepted with no response (deferred). Requests of commands 0 to 2 to any other line see `req_ready` 0.
- R6: A snoop to the locked line sees `snp_defer` 1 and is queued, including while the locked read waits for its fill. A snoop to any other line sees `snp_ready` 1 and `snp_defer` 0.
- R7: A locked write to the locked line is always accepted. It writes its data to the array and answers one cycle later with kind 4 and data 0.
- R8: After the kind-4 answer, the deferred targets are answered on consecutive cycles in arrival order: read kind 1 with the current line data (after the locked write and earlier replayed writes), write kind 2, snoop kind 5. No second kind-3 answer is given.
- R9: `lock_busy` falls at the same edge at which the last answer of the sequence appears. That answer is the final replayed target, or the kind-4 answer when nothing was deferred.
- R10: The target queue holds 4 entries. When it is full, `req_ready` is 0 for plain requests to the locked line and `snp_ready` is 0 for snoops to it, while a locked write is still accepted.
- R11: A locked read to the already-locked line, or a locked write with no lock or to a different line, is accepted without a response. It raises `lock_err` for one cycle, one cycle after acceptance, and leaves the lock unchanged.
- R12: The line address is the request address with bits 5:0 cleared (64-byte lines). `arr_addr` and `fetch_addr` always carry zero offset bits, and offsets within a line select the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_cmd | input | 2 | Command code |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 3 | Response kind code |
| rsp_data | output | DW | Response data |
| snp_valid | input | 1 | Snoop present |
| snp_addr | input | AW | Snoop byte address |
| snp_ready | output | 1 | Snoop accepted this cycle |
| snp_defer | output | 1 | Snoop is queued behind the lock |
| arr_addr | output | AW | Array line address |
| arr_hit | input | 1 | Array holds the line |
| arr_rdata | input | DW | Array line data |
| arr_we | output | 1 | Array write strobe |
| arr_wdata | output | DW | Array write data |
| fetch_valid | output | 1 | Downstream fetch outstanding |
| fetch_addr | output | AW | Line being fetched |
| fill_valid | input | 1 | Fill data returned |
| fill_data | input | DW | Fill data |
| lock_busy | output | 1 | Line lock or replay in progress |
| lock_err | output | 1 | Illegal locked command seen |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data, 64-byte lines and a 4-entry target queue. The shallow queue is filled by four deferred targets (two reads, a write and a snoop). That puts the full-queue backpressure and a full-length in-order replay within a short directed run. With 64-byte lines, offsets such as 0x05 and 0x3C can be shown to select the same line as their aligned address.

// File: rtl/rmw_line_lock.sv
module rmw_line_lock #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int QDEPTH     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [2:0]    rsp_kind,
  output logic [DW-1:0] rsp_data,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_ready,
  output logic          snp_defer,
  output logic [AW-1:0] arr_addr,
  input  logic          arr_hit,
  input  logic [DW-1:0] arr_rdata,
  output logic          arr_we,
  output logic [DW-1:0] arr_wdata,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  output logic          lock_busy,
  output logic          lock_err
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int PW  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW  = $clog2(QDEPTH + 1);
  localparam logic [1:0] C_RD = 2'd0, C_WR = 2'd1, C_LRD = 2'd2, C_LWR = 2'd3;
  localparam logic [1:0] Q_SNP = 2'd2;
  localparam logic [2:0] K_RD = 3'd1, K_WR = 3'd2, K_LRD = 3'd3, K_LWR = 3'd4, K_SNP = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOCK, S_REPLAY} st_t;
  st_t st;

  logic [AW-1:0] pend;
  logic          locked;
  logic [1:0]    qk [QDEPTH];
  logic [DW-1:0] qd [QDEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  wire [AW-1:0] req_line = {req_addr[AW-1:OFS], {OFS{1'b0}}};
  wire [AW-1:0] snp_line = {snp_addr[AW-1:OFS], {OFS{1'b0}}};
  wire req_on_lock = (req_line == pend);
  wire full        = (cnt == CW'(QDEPTH));
  wire defer_snp   = snp_valid && locked && (snp_line == pend);
  wire snp_push    = defer_snp && !full;

  assign snp_defer = defer_snp;
  assign snp_ready = !(defer_snp && full);

  always_comb begin
    case (st)
      S_IDLE:  req_ready = 1'b1;
      S_LOCK:  if (req_cmd == C_LWR || (req_on_lock && req_cmd == C_LRD)) req_ready = 1'b1;
               else req_ready = req_on_lock && !full && !snp_push;
      default: req_ready = 1'b0;
    endcase
  end

  wire acc      = req_valid && req_ready;
  wire req_push = acc && st == S_LOCK && req_on_lock && (req_cmd == C_RD || req_cmd == C_WR);
  wire unlock   = acc && st == S_LOCK && req_cmd == C_LWR && req_on_lock;
  wire pop      = (st == S_REPLAY) && (cnt != '0);
  wire push     = req_push || snp_push;
  wire [1:0]    head_k = qk[rp];
  wire [DW-1:0] head_d = qd[rp];

  assign arr_addr    = (st == S_IDLE) ? req_line : pend;
  assign arr_we      = (st == S_IDLE && acc && req_cmd == C_WR) || (st == S_FETCH && fill_valid)
                     || unlock || (pop && head_k == C_WR);
  assign arr_wdata   = (st == S_FETCH) ? fill_data : (st == S_REPLAY) ? head_d : req_wdata;
  assign fetch_valid = (st == S_FETCH);
  assign fetch_addr  = pend;
  assign lock_busy   = locked;

  always_ff @(posedge clk) begin
    if (push) begin
      qk[wp] <= req_push ? req_cmd : Q_SNP;
      qd[wp] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(QDEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(QDEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= '0; locked <= 1'b0;
      rsp_valid <= 1'b0; rsp_kind <= '0; rsp_data <= '0; lock_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0; rsp_kind <= '0; rsp_data <= '0; lock_err <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          case (req_cmd)
            C_RD: if (arr_hit) begin
                    rsp_valid <= 1'b1; rsp_kind <= K_RD; rsp_data <= arr_rdata;
                  end else begin
                    st <= S_FETCH; pend <= req_line;
                  end
            C_WR: begin rsp_valid <= 1'b1; rsp_kind <= K_WR; end
            C_LRD: begin
              pend <= req_line; locked <= 1'b1;
              if (arr_hit) begin
                rsp_valid <= 1'b1; rsp_kind <= K_LRD; rsp_data <= arr_rdata; st <= S_LOCK;
              end else st <= S_FETCH;
            end
            default: lock_err <= 1'b1;
          endcase
        end
        S_FETCH: if (fill_valid) begin
          rsp_valid <= 1'b1; rsp_kind <= locked ? K_LRD : K_RD; rsp_data <= fill_data;
          st <= locked ? S_LOCK : S_IDLE;
        end
        S_LOCK: if (acc) begin
          if (unlock) begin
            rsp_valid <= 1'b1; rsp_kind <= K_LWR;
            if (cnt != '0 || snp_push) st <= S_REPLAY;
            else begin st <= S_IDLE; locked <= 1'b0; end
          end else if (req_cmd == C_LWR || req_cmd == C_LRD) lock_err <= 1'b1;
        end
        default: if (pop) begin
          rsp_valid <= 1'b1;
          rsp_kind  <= (head_k == C_RD) ? K_RD : (head_k == C_WR) ? K_WR : K_SNP;
          rsp_data  <= (head_k == C_RD) ? arr_rdata : '0;
          if (cnt == CW'(1) && !snp_push) begin st <= S_IDLE; locked <= 1'b0; end
        end else begin
          st <= S_IDLE; locked <= 1'b0;
        end
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(QDEPTH));
  // R3
  lrd_hit_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && acc && req_cmd == C_LRD && arr_hit) |=> (!fetch_valid && lock_busy && rsp_kind == K_LRD));
  // R8
  single_lrd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_REPLAY) |-> !(rsp_valid && rsp_kind == K_LRD));
  // R5
  stall_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_busy && req_valid && req_ready) |-> (req_on_lock || req_cmd == C_LWR));
  // R9
  unlock_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_busy) |-> (cnt == '0 && rsp_valid));
  // R6
  defer_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_defer && snp_ready) |=> (cnt != '0));
  // R11
  err_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n) lock_err |-> !rsp_valid);
endmodule

// File: tb/test_rmw_line_lock.sv
module test_rmw_line_lock;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, snp_valid = 0, fill_valid = 0;
  logic [1:0] req_cmd = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, snp_addr = 0, fill_data = 0;
  logic req_ready, rsp_valid, snp_ready, snp_defer, arr_hit, arr_we, fetch_valid, lock_busy, lock_err;
  logic [2:0] rsp_kind;
  logic [31:0] rsp_data, arr_addr, arr_rdata, arr_wdata, fetch_addr;
  logic [31:0] mem [16];
  logic mv [16];
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  rmw_line_lock i_rmw_line_lock (.*);

  assign arr_hit   = mv[arr_addr[9:6]];
  assign arr_rdata = mem[arr_addr[9:6]];
  always @(posedge clk) if (arr_we) begin mem[arr_addr[9:6]] <= arr_wdata; mv[arr_addr[9:6]] <= 1'b1; end

  localparam logic [1:0]  T_CMD  [8] = '{0, 1, 0, 1, 0, 0, 1, 0};
  localparam logic [31:0] T_ADDR [8] = '{32'h40, 32'h85, 32'hBC, 32'hC0, 32'hFF, 32'h100, 32'h41, 32'h7F};
  localparam logic [31:0] T_WD   [8] = '{0, 32'hDEAD0002, 0, 32'h12345678, 0, 0, 32'h0BADF00D, 0};
  localparam logic [2:0]  T_KIND [8] = '{1, 2, 1, 2, 1, 1, 2, 1};
  localparam logic [31:0] T_EXP  [8] = '{32'hA0000001, 0, 32'hDEAD0002, 0, 32'h12345678,
                                         32'hA0000004, 0, 32'h0BADF00D};

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] c, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = a; req_wdata = d;
    #1 chk("req accepted", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic exp_rsp(input string r, input logic [2:0] k, input logic [31:0] d);
    chk(r, {28'd0, rsp_valid, rsp_kind}, {28'd0, 1'b1, k});
    chk(r, rsp_data, d);
  endtask

  task automatic snoop(input logic [31:0] a, input logic exp_rdy, input logic exp_def, input string r);
    @(negedge clk);
    snp_valid = 1; snp_addr = a;
    #1 chk(r, {30'd0, snp_ready, snp_defer}, {30'd0, exp_rdy, exp_def});
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 32'hA0000000 + i; mv[i] = (i != 5); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 outputs", {27'd0, rsp_valid, lock_busy, lock_err, fetch_valid, req_ready}, 32'h1);

    // R2 and R12: plain traffic, offsets map to the same line
    for (int i = 0; i < 8; i++) begin
      do_req(T_CMD[i], T_ADDR[i], T_WD[i]);
      exp_rsp("R2/R12 table", T_KIND[i], T_EXP[i]);
    end

    // R3 locked read hit on line 0x40
    do_req(2, 32'h48, 0);
    exp_rsp("R3 lrd hit", 3, 32'h0BADF00D);
    chk("R3 busy/no fetch", {30'd0, lock_busy, fetch_valid}, 32'h2);

    // R5 other line stalls
    @(negedge clk);
    req_valid = 1; req_cmd = 0; req_addr = 32'h80;
    #1 chk("R5 stall other line", 32'(req_ready), 0);
    req_valid = 0;

    // R5 deferred plain accesses, R6 snoops
    do_req(0, 32'h44, 0);
    chk("R5 deferred read no rsp", 32'(rsp_valid), 0);
    do_req(1, 32'h50, 32'h55);
    chk("R5 deferred write no rsp", 32'(rsp_valid), 0);
    snoop(32'h7C, 1, 1, "R6 snoop locked line");
    snoop(32'h200, 1, 0, "R6 snoop other line");
    do_req(0, 32'h40, 0);

    // R10 queue full
    @(negedge clk);
    req_valid = 1; req_cmd = 0; req_addr = 32'h40;
    #1 chk("R10 full req", 32'(req_ready), 0);
    req_cmd = 3;
    #1 chk("R10 lwr still accepted", 32'(req_ready), 1);
    req_valid = 0; snp_valid = 1; snp_addr = 32'h40;
    #1 chk("R10 full snoop", {30'd0, snp_ready, snp_defer}, 32'h1);
    snp_valid = 0;

    // R7 locked write, R8 replay order, R9 busy
    do_req(3, 32'h40, 32'h77);
    exp_rsp("R7 lwr rsp", 4, 0);
    chk("R9 busy during replay", 32'(lock_busy), 1);
    @(negedge clk); exp_rsp("R8 replay read 1", 1, 32'h77);
    @(negedge clk); exp_rsp("R8 replay write", 2, 0);
    @(negedge clk); exp_rsp("R8 replay snoop", 5, 0);
    chk("R9 busy before last", 32'(lock_busy), 1);
    @(negedge clk); exp_rsp("R8 replay read 2", 1, 32'h55);
    chk("R9 busy falls with last", 32'(lock_busy), 0);
    @(negedge clk);
    chk("R8 no extra rsp", 32'(rsp_valid), 0);

    // R4 locked read miss on line 0x140
    do_req(2, 32'h144, 0);
    chk("R4 no rsp before fill", 32'(rsp_valid), 0);
    chk("R4 fetch valid", 32'(fetch_valid), 1);
    chk("R12 fetch addr aligned", fetch_addr, 32'h140);
    snoop(32'h150, 1, 1, "R6 snoop during fill wait");
    @(negedge clk);
    fill_valid = 1; fill_data = 32'hABC00C;
    @(negedge clk);
    fill_valid = 0;
    exp_rsp("R4 fill rsp", 3, 32'hABC00C);
    chk("R4 locked after fill", {30'd0, lock_busy, fetch_valid}, 32'h2);
    do_req(3, 32'h140, 32'h99);
    exp_rsp("R7 lwr after miss", 4, 0);
    @(negedge clk); exp_rsp("R8 replay snoop after miss", 5, 0);
    chk("R9 unlock after snoop", 32'(lock_busy), 0);
    do_req(0, 32'h148, 0);
    exp_rsp("R4/R7 committed data", 1, 32'h99);

    // R11 errors
    do_req(3, 32'h40, 32'h1);
    chk("R11 lwr without lock err", {30'd0, lock_err, rsp_valid}, 32'h2);
    do_req(2, 32'h40, 0);
    exp_rsp("R3 relock", 3, 32'h55);
    do_req(2, 32'h60, 0);
    chk("R11 lrd on held line", {30'd0, lock_err, rsp_valid}, 32'h2);
    do_req(3, 32'h80, 32'h2);
    chk("R11 lwr other line", {30'd0, lock_err, rsp_valid}, 32'h2);
    chk("R11 lock kept", 32'(lock_busy), 1);
    do_req(3, 32'h40, 32'h66);
    exp_rsp("R7 lwr empty queue", 4, 0);
    chk("R9 unlock with lwr rsp", 32'(lock_busy), 0);
    do_req(0, 32'h40, 0);
    exp_rsp("R7 data after unlock", 1, 32'h66);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule